// File: doc/BRIEF.md
# Strategy-Sequenced At-Speed Redundancy Analyzer

This block decides how to spend a fixed budget of spare rows and spare columns on a word-oriented memory while the built-in self-test is running. On every failing read the test engine hands it the row address and a fail map that holds one bit per data bit. The analyzer follows one repair strategy at a time. A strategy is a fixed sequence of picks, each pick being either a row or a column. The analyzer keeps a small list of allocated rows and a column repair vector, which marks the bit positions already covered by spare columns.

When the current strategy cannot cover a new failure, the analyzer moves on to the next strategy, clears what it has allocated, and sends a one-cycle restart pulse so that the self-test runs again from the beginning. With m spare rows and n spare columns there are C(m+n, m) strategies, and they are tried in a fixed order. If a test run ends without breaking the strategy in use, the row list and the column vector are held as the repair result. If the last strategy also breaks, the memory is declared unrepairable and no further restart is sent.

Top module: `bira_strategy_engine`

## Requirements
- R1: After reset no flag is raised, restart is low, nothing is allocated (`rep_row_vld` and `rep_cols` are zero) and `strategy` holds the first strategy. For 2 rows and 2 columns that value is 4'b0011.
- R2: A strategy is an (m+n)-bit code. Bit m+n-1 is the first pick and bit 0 the last, with 1 meaning column and 0 meaning row. Each code has exactly n ones. Codes are tried in increasing numeric order, so a row sorts before a column. For 2x2 the order is 0011, 0101, 0110, 1001, 1010, 1100.
- R3: A failing read consumes no spare when its row is already allocated, or when every set bit of its fail map is already set in the column vector.
- R4: When the pick in use is a column, the fail map is ORed into `rep_cols` and the pick pointer advances.
- R5: When the pick in use is a row, the row address goes into the lowest free slot of `rep_rows`. Slot i is bits [i*ROW_W +: ROW_W], and its bit in `rep_row_vld` is set.
- R6: The strategy breaks when a new spare is needed and either all m+n picks are used, or a column pick would leave more than n bits set in the column vector. One cycle later `restart` is high for one cycle, `strategy` holds the next code, and all allocations are cleared.
- R7: If `bist_done` arrives while running and the strategy has not broken, `repair_ok` is set and the repair data is frozen. Later failing reads do not change it.
- R8: When the last strategy breaks, `unrepairable` is set, no restart is issued, and later failing reads change nothing.
- R9: When a failing read and `bist_done` come in the same cycle, the read is analyzed first. If the read breaks the strategy, the restart wins and `repair_ok` stays low. Otherwise the allocation is applied and `repair_ok` is set.
- R10: A `start` pulse clears both flags and all allocations, loads the first strategy and begins analysis. Before the first `start`, failing reads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin analysis from the first strategy |
| bist_fail | input | 1 | A failing read is presented this cycle |
| fail_map | input | DATA_W | Failing bit positions of the read |
| fail_row | input | ROW_W | Row address of the failing read |
| bist_done | input | 1 | The test run has ended |
| restart | output | 1 | One-cycle request to rerun the test |
| repair_ok | output | 1 | Repair data valid |
| unrepairable | output | 1 | All strategies exhausted |
| strategy | output | SPARE_ROWS+SPARE_COLS | Code of the strategy in use |
| rep_rows | output | SPARE_ROWS*ROW_W | Allocated row addresses, one slot per spare row |
| rep_row_vld | output | SPARE_ROWS | Slot occupied |
| rep_cols | output | DATA_W | Column repair vector |

## Verification
A failing read and the end of a test run can land in the same cycle. The bench provokes this by raising `bist_fail` and `bist_done` together, once with a read that only takes a row pick and once with a read whose column pick overflows the budget. The bench then judges which outcome took effect: `repair_ok` with the new row stored, or a restart pulse with the next strategy code and `repair_ok` still low. It also walks the whole strategy sequence, checking the code after every restart and the final unrepairable state.

// File: rtl/bira_pkg.sv
package bira_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PASS = 2'd2,
    ST_FAIL = 2'd3
  } bira_state_e;

  // number of set bits in a vector of up to 64 bits
  function automatic int unsigned ones64(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  // lowest code holding `w` ones in `k` bits: all rows first
  function automatic logic [63:0] first_code(input int k, input int w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) if (i < w && i < k) r[i] = 1'b1;
    return r;
  endfunction

  // highest code: all columns first
  function automatic logic [63:0] last_code(input int k, input int w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) if (i >= k - w && i < k) r[i] = 1'b1;
    return r;
  endfunction

  // next larger value with the same number of ones (x must be non-zero)
  function automatic logic [63:0] next_code(input logic [63:0] x);
    logic [63:0] low, rip, mix;
    int unsigned tz;
    low = x & (~x + 64'd1);
    rip = x + low;
    mix = rip ^ x;
    tz  = 0;
    for (int i = 63; i >= 0; i--) if (low[i]) tz = i;
    return ((mix >> 2) >> tz) | rip;
  endfunction

endpackage

// File: rtl/bira_row_store.sv
module bira_row_store #(
  parameter int ROW_W = 4,
  parameter int SLOTS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [ROW_W-1:0]       wr_row,
  input  logic [ROW_W-1:0]       look_row,
  output logic                   hit,
  output logic                   full,
  output logic [SLOTS*ROW_W-1:0] rows_flat,
  output logic [SLOTS-1:0]       vld
);
  localparam int FILL_W = $clog2(SLOTS + 1);

  logic [ROW_W-1:0]  row_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;
  logic [FILL_W-1:0] fill_q;
  logic [SLOTS-1:0]  match;

  assign full = (fill_q == FILL_W'(SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (wr_en && !full) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (clr) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en && fill_q == FILL_W'(g)) begin
        row_q[g] <= wr_row;
        vld_q[g] <= 1'b1;
      end
    end
    assign match[g] = vld_q[g] && (row_q[g] == look_row);
    assign rows_flat[g*ROW_W +: ROW_W] = row_q[g];
  end

  assign hit = |match;
  assign vld = vld_q;

  // a row pick is never requested once every slot is taken (R5)
  p_no_write_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // slots fill from the bottom up (R5)
  p_slots_packed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld_q + 1'b1) || (vld_q == '0));
endmodule

// File: rtl/bira_col_vector.sv
module bira_col_vector
  import bira_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NCOLS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              merge_en,
  input  logic [DATA_W-1:0] probe_bits,
  output logic [DATA_W-1:0] crv,
  output logic              covered,
  output logic              over
);
  logic [DATA_W-1:0] crv_q;
  logic [DATA_W-1:0] merged;

  assign merged  = crv_q | probe_bits;
  assign covered = ((probe_bits & ~crv_q) == '0);
  assign over    = ones64(64'(merged)) > NCOLS;
  assign crv     = crv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crv_q <= '0;
    else if (clr)      crv_q <= '0;
    else if (merge_en) crv_q <= merged;
  end

  // the vector never holds more covered bits than there are spare columns (R6)
  p_col_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(crv_q) <= NCOLS);
  // an overflowing column pick is never merged (R6)
  p_no_merge_over_r6: assert property (@(posedge clk) disable iff (!rst_n)
    merge_en |-> !over);
endmodule

// File: rtl/bira_strategy_seq.sv
module bira_strategy_seq
  import bira_pkg::*;
#(
  parameter int NROWS = 2,
  parameter int NCOLS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_first,
  input  logic                   advance,
  input  logic                   consume,
  output logic [NROWS+NCOLS-1:0] code,
  output logic                   pick_col,
  output logic                   picks_left,
  output logic                   is_last
);
  localparam int STEPS = NROWS + NCOLS;
  localparam int PTR_W = $clog2(STEPS + 1);
  localparam logic [STEPS-1:0] FIRST = STEPS'(first_code(STEPS, NCOLS));
  localparam logic [STEPS-1:0] LAST  = STEPS'(last_code(STEPS, NCOLS));

  logic [STEPS-1:0] code_q;
  logic [STEPS-1:0] code_nx;
  logic [PTR_W-1:0] ptr_q;

  assign code_nx    = STEPS'(next_code(64'(code_q)));
  assign is_last    = (code_q == LAST);
  assign picks_left = (ptr_q < PTR_W'(STEPS));
  assign code       = code_q;

  always_comb begin
    pick_col = 1'b0;
    for (int i = 0; i < STEPS; i++)
      if (ptr_q == PTR_W'(i)) pick_col = code_q[STEPS-1-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= FIRST;
      ptr_q  <= '0;
    end else if (load_first) begin
      code_q <= FIRST;
      ptr_q  <= '0;
    end else if (advance) begin
      code_q <= code_nx;
      ptr_q  <= '0;
    end else if (consume) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  // every code spends exactly the column budget (R2)
  p_code_weight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(code_q) == NCOLS);
  // codes only ever grow between starts (R2)
  p_code_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load_first |=> code_q > $past(code_q));
endmodule

// File: rtl/bira_strategy_engine.sv
module bira_strategy_engine
  import bira_pkg::*;
#(
  parameter int ROW_W      = 4,
  parameter int DATA_W     = 8,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic                             bist_fail,
  input  logic [DATA_W-1:0]                fail_map,
  input  logic [ROW_W-1:0]                 fail_row,
  input  logic                             bist_done,
  output logic                             restart,
  output logic                             repair_ok,
  output logic                             unrepairable,
  output logic [SPARE_ROWS+SPARE_COLS-1:0] strategy,
  output logic [SPARE_ROWS*ROW_W-1:0]      rep_rows,
  output logic [SPARE_ROWS-1:0]            rep_row_vld,
  output logic [DATA_W-1:0]                rep_cols
);
  bira_state_e state_q;
  logic restart_q;

  // named internal events
  logic running, fail_ev, row_hit, bits_covered, col_over;
  logic pick_col, picks_left, is_last, rows_full;
  logic need_spare, take_row, take_col, strat_break;
  logic advance_ev, give_up_ev, pass_ev, clear_ev;

  assign running     = (state_q == ST_RUN);
  assign fail_ev     = running && bist_fail;
  assign need_spare  = fail_ev && !row_hit && !bits_covered;
  assign take_row    = need_spare && picks_left && !pick_col;
  assign take_col    = need_spare && picks_left && pick_col && !col_over;
  assign strat_break = need_spare && (!picks_left || (pick_col && col_over));
  assign advance_ev  = strat_break && !is_last;
  assign give_up_ev  = strat_break && is_last;
  assign pass_ev     = running && bist_done && !strat_break;
  assign clear_ev    = start || advance_ev;

  bira_strategy_seq #(.NROWS(SPARE_ROWS), .NCOLS(SPARE_COLS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_first (start),
    .advance    (advance_ev),
    .consume    (take_row || take_col),
    .code       (strategy),
    .pick_col   (pick_col),
    .picks_left (picks_left),
    .is_last    (is_last)
  );

  bira_row_store #(.ROW_W(ROW_W), .SLOTS(SPARE_ROWS)) u_rows (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clear_ev),
    .wr_en     (take_row),
    .wr_row    (fail_row),
    .look_row  (fail_row),
    .hit       (row_hit),
    .full      (rows_full),
    .rows_flat (rep_rows),
    .vld       (rep_row_vld)
  );

  bira_col_vector #(.DATA_W(DATA_W), .NCOLS(SPARE_COLS)) u_cols (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clear_ev),
    .merge_en   (take_col),
    .probe_bits (fail_map),
    .crv        (rep_cols),
    .covered    (bits_covered),
    .over       (col_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      restart_q <= 1'b0;
    end else begin
      restart_q <= advance_ev && !start;
      if (start)           state_q <= ST_RUN;
      else if (give_up_ev) state_q <= ST_FAIL;
      else if (pass_ev)    state_q <= ST_PASS;
    end
  end

  assign restart      = restart_q;
  assign repair_ok    = (state_q == ST_PASS);
  assign unrepairable = (state_q == ST_FAIL);

  // a row pick always finds a free slot (R5)
  p_row_pick_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_row |-> !rows_full);
  // both verdicts are never raised together (R7)
  p_verdict_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(repair_ok && unrepairable));
  // a restart always brings a new code and empty allocations (R6)
  p_restart_new_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (strategy != $past(strategy)) && (rep_row_vld == '0) && (rep_cols == '0));
  // once exhausted the analyzer stays quiet until the next start (R8)
  p_unrep_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unrepairable && !start |=> unrepairable && !restart);
  // frozen repair data (R7)
  p_pass_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    repair_ok && !start |=> repair_ok && $stable(rep_cols) && $stable(rep_row_vld));
endmodule

// File: tb/sim_bira_strategy_engine.sv
module sim_bira_strategy_engine;
  localparam int RW = 4, DW = 8, NR = 2, NC = 2, K = NR + NC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, bist_fail = 0, bist_done = 0;
  logic [DW-1:0] fail_map = '0;
  logic [RW-1:0] fail_row = '0;
  logic restart, repair_ok, unrepairable;
  logic [K-1:0] strategy;
  logic [NR*RW-1:0] rep_rows;
  logic [NR-1:0] rep_row_vld;
  logic [DW-1:0] rep_cols;
  int vecs = 0, errs = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bira_strategy_engine #(.ROW_W(RW), .DATA_W(DW), .SPARE_ROWS(NR), .SPARE_COLS(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .bist_fail(bist_fail), .fail_map(fail_map),
    .fail_row(fail_row), .bist_done(bist_done), .restart(restart), .repair_ok(repair_ok),
    .unrepairable(unrepairable), .strategy(strategy), .rep_rows(rep_rows),
    .rep_row_vld(rep_row_vld), .rep_cols(rep_cols));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench's own enumeration: next K-bit value with NC ones
  function automatic logic [K-1:0] after(input logic [K-1:0] cur);
    for (int v = int'(cur) + 1; v < (1 << K); v++) begin
      int c = 0;
      for (int b = 0; b < K; b++) c += (v >> b) & 1;
      if (c == NC) return K'(v);
    end
    return cur;
  endfunction

  task automatic go();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic rd(input logic [RW-1:0] row, input logic [DW-1:0] map, input bit done = 0);
    @(negedge clk); bist_fail = 1; fail_row = row; fail_map = map; bist_done = done;
    @(negedge clk); bist_fail = 0; bist_done = 0;
  endtask

  task automatic fin();
    @(negedge clk); bist_done = 1;
    @(negedge clk); bist_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 repair_ok", repair_ok, 0);
    chk("R1 unrepairable", unrepairable, 0);
    chk("R1 restart", restart, 0);
    chk("R1 strategy", strategy, 4'b0011);
    chk("R1 rows", rep_row_vld, 0);
    chk("R1 cols", rep_cols, 0);
    rd(4'd6, 8'h01);
    chk("R10 ignored before start", rep_row_vld, 0);
  endtask

  task automatic t_basic();
    go();
    rd(4'd3, 8'h01);
    chk("R5 first row slot", rep_row_vld, 2'b01);
    rd(4'd3, 8'hFF);
    chk("R3 row already taken", rep_row_vld, 2'b01);
    chk("R3 row taken cols", rep_cols, 0);
    rd(4'd5, 8'h02);
    chk("R5 second row", rep_rows, 8'h53);
    rd(4'd7, 8'h04);
    chk("R4 column pick", rep_cols, 8'h04);
    rd(4'd9, 8'h04);
    chk("R3 bits covered", rep_cols, 8'h04);
    chk("R3 no restart", restart, 0);
    fin();
    chk("R7 repair_ok", repair_ok, 1);
    rd(4'd11, 8'h80);
    chk("R7 frozen cols", rep_cols, 8'h04);
    chk("R7 frozen rows", {rep_row_vld, rep_rows}, {2'b11, 8'h53});
  endtask

  task automatic t_column_merge();
    go();
    rd(4'd1, 8'h01);
    rd(4'd1, 8'h80);
    rd(4'd2, 8'h11);
    chk("R5 rows", {rep_row_vld, rep_rows}, {2'b11, 8'h21});
    rd(4'd6, 8'h11);
    chk("R4 two-bit merge", rep_cols, 8'h11);
    rd(4'd7, 8'h10);
    chk("R3 subset covered", rep_cols, 8'h11);
    fin();
    chk("R7 pass", repair_ok, 1);
  endtask

  task automatic t_picks_used();
    go();
    rd(4'd1, 8'h01); rd(4'd2, 8'h01); rd(4'd3, 8'h01); rd(4'd4, 8'h02);
    chk("R4 cols before exhaustion", rep_cols, 8'h03);
    rd(4'd5, 8'h04);
    chk("R6 restart on no picks", restart, 1);
    chk("R6 next strategy", strategy, 4'b0101);
    chk("R6 cleared", {rep_row_vld, rep_cols}, 0);
    @(negedge clk);
    chk("R6 pulse one cycle", restart, 0);
  endtask

  task automatic t_walk_all();
    logic [K-1:0] exp_s = 4'b0011;
    go();
    for (int s = 0; s < 6; s++) begin
      bit hit = 0;
      chk("R2 strategy order", strategy, exp_s);
      for (int r = 1; r <= 5 && !hit; r++) begin
        rd(4'(r), 8'h0F);
        if (restart || unrepairable) hit = 1;
      end
      if (s < 5) begin
        chk("R6 restart raised", restart, 1);
        chk("R8 not yet unrepairable", unrepairable, 0);
        exp_s = after(exp_s);
      end else begin
        chk("R8 unrepairable", unrepairable, 1);
        chk("R8 no restart", restart, 0);
      end
    end
    begin
      logic [DW-1:0] c0 = rep_cols;
      rd(4'd9, 8'hF0);
      chk("R8 cols unchanged", rep_cols, c0);
      chk("R8 still unrepairable", unrepairable, 1);
      chk("R8 still no restart", restart, 0);
    end
    go();
    chk("R10 flags cleared", {repair_ok, unrepairable}, 0);
    chk("R10 first strategy", strategy, 4'b0011);
  endtask

  task automatic t_same_cycle();
    go();
    rd(4'd4, 8'h01, 1);
    chk("R9 pass with row", repair_ok, 1);
    chk("R9 row stored", {rep_row_vld, rep_rows[3:0]}, {2'b01, 4'd4});
    go();
    rd(4'd1, 8'h0F); rd(4'd2, 8'h0F);
    rd(4'd3, 8'h0F, 1);
    chk("R9 restart wins", restart, 1);
    chk("R9 no pass", repair_ok, 0);
    chk("R9 advanced", strategy, 4'b0101);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_column_merge();
    t_picks_used();
    t_walk_all();
    t_same_cycle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule